// File: doc/BRIEF.md
# Retrace-Synchronized Status and Colormap Controller

This block is the control and status register file for a video output path. A host reads and writes it through a simple single-cycle register bus. It holds the display settings: video enable, raster mode and resolution code. It reports the vertical retrace state and a pending end-of-retrace interrupt. It also holds the general-purpose interrupt controls.

The block owns three shadow colormaps, one each for red, green and blue. Software fills them through the bus and then sets an update bit. On the next vertical retrace the block streams the shadow entries, one per clock, to the active colormap outside the block. The stream pauses whenever retrace is low and resumes when retrace returns. When the last entry has been sent, the update bit clears itself. While an update is pending, host writes to the shadow maps are silently discarded, so the copied table cannot be torn.

Top module: `rtr_cmap_ctrl`

## Requirements
- R1: After reset, the control word and the extended word read zero, except the bus-enabled bit, which follows its input. After reset `irq_o`, `video_en_o` and `copy_valid_o` are low.
- R2: The control word sits at address 0. Its bit 0 is video enable and bit 1 is interrupt enable. Bits 5:3 hold the raster mode and bits 9:6 hold the resolution code. The resolution codes are 0 = 1152x900, 1 = 1024x1024, 2 = 1600x1280 and 3 = 1440x1440. These bits are writable, read back unchanged, and drive `video_en_o`, `raster_mode_o` and `resolution_o`.
- R3: Control bit 10 reads the retrace input as it was one clock earlier. Control bit 11 is interrupt pending. It is set on the clock after `retrace_i` falls, but only if interrupt enable is 1. With interrupt enable at 0, a falling retrace leaves it clear.
- R4: Writing the control word with bit 11 set clears interrupt pending. `irq_o` is high when interrupt pending is set, or when the general-purpose request is set and the general-purpose disable is clear.
- R5: The extended word sits at address 1. Bit 0 is the general-purpose interrupt request and bit 1 is its disable; both are writable. Bit 15 is read-only and returns `gp_bus_en_i`.
- R6: The shadow maps are addressed with address bits [IDX_W+1:IDX_W] as the channel (1 = red, 2 = green, 3 = blue) and the low IDX_W bits as the entry index. A write stores the low COMP_W bits of write data. A read returns the stored entry, zero-extended.
- R7: Writing the control word with bit 2 set makes the update pending, and control bit 2 then reads 1. While the update is pending and `retrace_i` is high, `copy_valid_o` is high. Entries go out in ascending index order, one per clock. `copy_rgb_o` is {red, green, blue}. The stream pauses while retrace is low and resumes at the next index.
- R8: While an update is pending, writes to any shadow map are dropped, and the stored entries keep their old values.
- R9: The pending update clears itself on the clock that transfers the last entry. Writing 0 to control bit 2 does not clear it.
- R10: Writes to the read-only bits (retrace and bus enabled) have no effect on what they read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | IDX_W+2 | Register / colormap address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| retrace_i | input | 1 | Vertical retrace from the timing generator |
| gp_bus_en_i | input | 1 | General-purpose bus enabled status |
| irq_o | output | 1 | Interrupt request |
| video_en_o | output | 1 | Video DAC enable |
| raster_mode_o | output | 3 | Raster mode field |
| resolution_o | output | 4 | Resolution code |
| copy_valid_o | output | 1 | Active-colormap write strobe |
| copy_idx_o | output | IDX_W | Entry index being copied |
| copy_rgb_o | output | 3*COMP_W | Entry data {red, green, blue} |

## Verification
The bench builds the block with ENTRIES = 16 and COMP_W = 8. A full colormap copy then fits in a few dozen cycles. This lets the bench check every copied entry against its own shadow model. It also brings within reach a copy that is paused mid-table by retrace dropping and then resumed, and the self-clear on the last index. The 8-bit component width keeps the {red, green, blue} packing easy to check field by field.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
  localparam int unsigned DATA_W   = 16;
  localparam int unsigned C_VID    = 0;
  localparam int unsigned C_IRQEN  = 1;
  localparam int unsigned C_UPD    = 2;
  localparam int unsigned C_MODE_L = 3;
  localparam int unsigned C_RES_L  = 6;
  localparam int unsigned C_RTR    = 10;
  localparam int unsigned C_IPEND  = 11;
  localparam int unsigned X_GPREQ  = 0;
  localparam int unsigned X_GPDIS  = 1;
  localparam int unsigned X_BUSEN  = 15;

  typedef enum logic [1:0] {
    SEL_REG   = 2'd0,
    SEL_RED   = 2'd1,
    SEL_GREEN = 2'd2,
    SEL_BLUE  = 2'd3
  } sel_e;

  // Interrupt line combination.
  function automatic logic irq_line(input logic ipend, input logic gpreq, input logic gpdis);
    return ipend | (gpreq & ~gpdis);
  endfunction
endpackage

// File: rtl/rcc_csr.sv
module rcc_csr
  import rcc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctl,
  input  logic              wr_ext,
  input  logic [DATA_W-1:0] wdata,
  input  logic              retrace_i,
  input  logic              upd_done,
  output logic              vid_en,
  output logic              irq_en,
  output logic [2:0]        mode,
  output logic [3:0]        res,
  output logic              upd_pend,
  output logic              irq_pend,
  output logic              rtr_q,
  output logic              rtr_fall,
  output logic              gp_req,
  output logic              gp_dis
);
  assign rtr_fall = rtr_q & ~retrace_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vid_en   <= 1'b0;
      irq_en   <= 1'b0;
      mode     <= '0;
      res      <= '0;
      upd_pend <= 1'b0;
      irq_pend <= 1'b0;
      rtr_q    <= 1'b0;
      gp_req   <= 1'b0;
      gp_dis   <= 1'b0;
    end else begin
      rtr_q <= retrace_i;
      if (wr_ctl) begin
        vid_en <= wdata[C_VID];
        irq_en <= wdata[C_IRQEN];
        mode   <= wdata[C_MODE_L +: 3];
        res    <= wdata[C_RES_L +: 4];
      end
      if (upd_done)
        upd_pend <= 1'b0;
      else if (wr_ctl && wdata[C_UPD])
        upd_pend <= 1'b1;
      if (rtr_fall && irq_en)
        irq_pend <= 1'b1;
      else if (wr_ctl && wdata[C_IPEND])
        irq_pend <= 1'b0;
      if (wr_ext) begin
        gp_req <= wdata[X_GPREQ];
        gp_dis <= wdata[X_GPDIS];
      end
    end
  end
endmodule

// File: rtl/rcc_cmap.sv
module rcc_cmap #(
  parameter int unsigned ENTRIES = 256,
  parameter int unsigned COMP_W  = 8,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                map_wr,
  input  logic [1:0]          map_sel,
  input  logic [IDX_W-1:0]    host_idx,
  input  logic [COMP_W-1:0]   host_data,
  input  logic                upd_pend,
  input  logic                retrace_i,
  output logic [COMP_W-1:0]   rd_data [3],
  output logic                map_wr_accept,
  output logic                copy_valid,
  output logic [IDX_W-1:0]    copy_idx,
  output logic [3*COMP_W-1:0] copy_rgb,
  output logic                upd_done
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  function automatic logic [IDX_W-1:0] step_idx(input logic [IDX_W-1:0] i);
    return (i == LAST) ? '0 : i + 1'b1;
  endfunction

  logic [COMP_W-1:0] cp_data [3];

  assign map_wr_accept = map_wr & ~upd_pend;
  assign copy_valid    = upd_pend & retrace_i;
  assign upd_done      = copy_valid && (copy_idx == LAST);

  for (genvar ch = 0; ch < 3; ch++) begin : g_chan
    logic [COMP_W-1:0] mem [ENTRIES];
    always_ff @(posedge clk) begin
      if (map_wr_accept && (map_sel == 2'(ch + 1)))
        mem[host_idx] <= host_data;
    end
    assign rd_data[ch] = mem[host_idx];
    assign cp_data[ch] = mem[copy_idx];
  end

  assign copy_rgb = {cp_data[0], cp_data[1], cp_data[2]};

  always_ff @(posedge clk) begin
    if (!rst_n)
      copy_idx <= '0;
    else if (copy_valid)
      copy_idx <= step_idx(copy_idx);
  end
endmodule

// File: rtl/rtr_cmap_ctrl.sv
module rtr_cmap_ctrl
  import rcc_pkg::*;
#(
  parameter int unsigned ENTRIES = 256,
  parameter int unsigned COMP_W  = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_wr,
  input  logic [$clog2(ENTRIES)+1:0]    bus_addr,
  input  logic [15:0]                   bus_wdata,
  output logic [15:0]                   bus_rdata,
  input  logic                          retrace_i,
  input  logic                          gp_bus_en_i,
  output logic                          irq_o,
  output logic                          video_en_o,
  output logic [2:0]                    raster_mode_o,
  output logic [3:0]                    resolution_o,
  output logic                          copy_valid_o,
  output logic [$clog2(ENTRIES)-1:0]    copy_idx_o,
  output logic [3*COMP_W-1:0]           copy_rgb_o
);
  localparam int unsigned IDX_W = $clog2(ENTRIES);

  logic [1:0] sel;
  logic       wr_ctl, wr_ext, map_wr, map_wr_accept;
  logic       irq_en, upd_pend, irq_pend, rtr_q, rtr_fall, gp_req, gp_dis, upd_done;
  logic [COMP_W-1:0] rd_data [3];

  assign sel    = bus_addr[IDX_W +: 2];
  assign wr_ctl = bus_wr && (sel == SEL_REG) && !bus_addr[0];
  assign wr_ext = bus_wr && (sel == SEL_REG) &&  bus_addr[0];
  assign map_wr = bus_wr && (sel != SEL_REG);

  rcc_csr u_csr (
    .clk(clk), .rst_n(rst_n), .wr_ctl(wr_ctl), .wr_ext(wr_ext), .wdata(bus_wdata),
    .retrace_i(retrace_i), .upd_done(upd_done), .vid_en(video_en_o), .irq_en(irq_en),
    .mode(raster_mode_o), .res(resolution_o), .upd_pend(upd_pend), .irq_pend(irq_pend),
    .rtr_q(rtr_q), .rtr_fall(rtr_fall), .gp_req(gp_req), .gp_dis(gp_dis)
  );

  rcc_cmap #(.ENTRIES(ENTRIES), .COMP_W(COMP_W)) u_cmap (
    .clk(clk), .rst_n(rst_n), .map_wr(map_wr), .map_sel(sel),
    .host_idx(bus_addr[IDX_W-1:0]), .host_data(bus_wdata[COMP_W-1:0]),
    .upd_pend(upd_pend), .retrace_i(retrace_i), .rd_data(rd_data),
    .map_wr_accept(map_wr_accept), .copy_valid(copy_valid_o), .copy_idx(copy_idx_o),
    .copy_rgb(copy_rgb_o), .upd_done(upd_done)
  );

  assign irq_o = irq_line(irq_pend, gp_req, gp_dis);

  always_comb begin
    bus_rdata = '0;
    case (sel)
      SEL_REG: begin
        if (!bus_addr[0]) begin
          bus_rdata[C_VID]          = video_en_o;
          bus_rdata[C_IRQEN]        = irq_en;
          bus_rdata[C_UPD]          = upd_pend;
          bus_rdata[C_MODE_L +: 3]  = raster_mode_o;
          bus_rdata[C_RES_L +: 4]   = resolution_o;
          bus_rdata[C_RTR]          = rtr_q;
          bus_rdata[C_IPEND]        = irq_pend;
        end else begin
          bus_rdata[X_GPREQ] = gp_req;
          bus_rdata[X_GPDIS] = gp_dis;
          bus_rdata[X_BUSEN] = gp_bus_en_i;
        end
      end
      SEL_RED:   bus_rdata[COMP_W-1:0] = rd_data[0];
      SEL_GREEN: bus_rdata[COMP_W-1:0] = rd_data[1];
      default:   bus_rdata[COMP_W-1:0] = rd_data[2];
    endcase
  end
endmodule

// File: rtl/rtr_cmap_ctrl_chk.sv
module rtr_cmap_ctrl_chk #(
  parameter int unsigned ENTRIES = 256,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             retrace_i,
  input logic             copy_valid_o,
  input logic [IDX_W-1:0] copy_idx_o,
  input logic             upd_pend,
  input logic             irq_pend,
  input logic             irq_en,
  input logic             rtr_fall,
  input logic             map_wr_accept,
  input logic             irq_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  a_r7_no_copy_outside_retrace: assert property (@(posedge clk) disable iff (!rst_n)
    !retrace_i |-> !copy_valid_o);

  a_r7_index_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (copy_valid_o && copy_idx_o != LAST) |=> (copy_idx_o == $past(copy_idx_o) + 1'b1));

  a_r8_lockout: assert property (@(posedge clk) disable iff (!rst_n)
    upd_pend |-> !map_wr_accept);

  a_r9_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (copy_valid_o && copy_idx_o == LAST) |=> !upd_pend);

  a_r3_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pend) |-> ($past(rtr_fall) && $past(irq_en)));

  a_r4_irq_line: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pend |-> irq_o);
endmodule

bind rtr_cmap_ctrl rtr_cmap_ctrl_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .retrace_i(retrace_i), .copy_valid_o(copy_valid_o),
  .copy_idx_o(copy_idx_o), .upd_pend(upd_pend), .irq_pend(irq_pend), .irq_en(irq_en),
  .rtr_fall(rtr_fall), .map_wr_accept(map_wr_accept), .irq_o(irq_o)
);

// File: tb/rtr_cmap_ctrl_tb.sv
module rtr_cmap_ctrl_tb_top;
  localparam int unsigned ENTRIES = 16;
  localparam int unsigned COMP_W  = 8;
  localparam int unsigned IDX_W   = $clog2(ENTRIES);
  localparam int unsigned AW      = IDX_W + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic retrace_i = 1'b0;
  logic gp_bus_en_i = 1'b0;
  logic irq_o, video_en_o, copy_valid_o;
  logic [2:0] raster_mode_o;
  logic [3:0] resolution_o;
  logic [IDX_W-1:0] copy_idx_o;
  logic [3*COMP_W-1:0] copy_rgb_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [7:0] m_r [ENTRIES];
  logic [7:0] m_g [ENTRIES];
  logic [7:0] m_b [ENTRIES];

  always #4 clk = ~clk;

  rtr_cmap_ctrl #(.ENTRIES(ENTRIES), .COMP_W(COMP_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .retrace_i(retrace_i), .gp_bus_en_i(gp_bus_en_i), .irq_o(irq_o),
    .video_en_o(video_en_o), .raster_mode_o(raster_mode_o), .resolution_o(resolution_o),
    .copy_valid_o(copy_valid_o), .copy_idx_o(copy_idx_o), .copy_rgb_o(copy_rgb_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [15:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic logic [AW-1:0] maddr(input int ch, input int idx);
    return AW'((ch << IDX_W) | idx);
  endfunction

  task automatic t_reset();
    logic [15:0] d;
    gp_bus_en_i = 1'b1;
    rd(0, d); check("R1 ctl reset", d, 0);
    rd(1, d); check("R1 ext reset", d, 16'h8000);
    check("R1 irq/vid/copy", {irq_o, video_en_o, copy_valid_o}, 0);
  endtask

  task automatic t_fields();
    logic [15:0] d;
    for (int r = 0; r < 4; r++) begin
      wr(0, 16'((r << 6) | (5 << 3) | 1));
      rd(0, d);
      check("R2 ctl readback", d, 32'((r << 6) | (5 << 3) | 1));
      check("R2 outputs", {video_en_o, raster_mode_o, resolution_o}, {1'b1, 3'd5, 4'(r)});
    end
    wr(0, 16'h0400);
    rd(0, d); check("R10 retrace bit not writable", d, 0);
  endtask

  task automatic t_irq();
    logic [15:0] d;
    wr(0, 16'h0002);
    @(negedge clk) retrace_i = 1'b1;
    @(negedge clk);
    rd(0, d); check("R3 retrace status", d[10], 1);
    retrace_i = 1'b0;
    check("R3 not yet pending", irq_o, 0);
    @(negedge clk);
    rd(0, d); check("R3 pending after fall", d[11], 1);
    check("R4 irq_o high", irq_o, 1);
    wr(0, 16'h0802);
    check("R4 ack clears", irq_o, 0);
    wr(0, 16'h0000);
    @(negedge clk) retrace_i = 1'b1;
    @(negedge clk) retrace_i = 1'b0;
    @(negedge clk);
    rd(0, d); check("R3 disabled no pend", d[11], 0);
  endtask

  task automatic t_ext();
    logic [15:0] d;
    gp_bus_en_i = 1'b0;
    wr(1, 16'h8001);
    rd(1, d); check("R5 ext readback", d, 16'h0001);
    check("R4 gp irq", irq_o, 1);
    wr(1, 16'h0003);
    check("R4 gp disabled", irq_o, 0);
    gp_bus_en_i = 1'b1;
    rd(1, d); check("R10 bus enabled follows pin", d, 16'h8003);
    wr(1, 16'h0000);
  endtask

  task automatic t_maps();
    logic [15:0] d;
    for (int i = 0; i < ENTRIES; i++) begin
      m_r[i] = 8'(i * 3 + 1); m_g[i] = 8'(8'hA0 ^ i); m_b[i] = 8'(255 - i * 5);
      wr(maddr(1, i), {8'hEE, m_r[i]});
      wr(maddr(2, i), {8'h00, m_g[i]});
      wr(maddr(3, i), {8'h00, m_b[i]});
    end
    for (int i = 0; i < ENTRIES; i += 5) begin
      rd(maddr(1, i), d); check("R6 red read", d, {8'h0, m_r[i]});
      rd(maddr(2, i), d); check("R6 green read", d, {8'h0, m_g[i]});
      rd(maddr(3, i), d); check("R6 blue read", d, {8'h0, m_b[i]});
    end
  endtask

  task automatic t_copy();
    logic [15:0] d;
    int errs = 0;
    wr(0, 16'h0004);
    rd(0, d); check("R7 pending set", d[2], 1);
    check("R7 no copy outside retrace", copy_valid_o, 0);
    wr(maddr(1, 0), 16'h0055);
    rd(maddr(1, 0), d); check("R8 write dropped", d, {8'h0, m_r[0]});
    for (int i = 0; i < ENTRIES; i++) begin
      if (i == 0 || i == 5) begin
        @(negedge clk) retrace_i = 1'b1;
      end
      #1;
      if (!copy_valid_o || copy_idx_o != IDX_W'(i) || copy_rgb_o != {m_r[i], m_g[i], m_b[i]}) begin
        errs++;
        check("R7 copy entry", {copy_valid_o, copy_idx_o, copy_rgb_o}, {1'b1, IDX_W'(i), m_r[i], m_g[i], m_b[i]});
      end
      @(negedge clk);
      if (i == 4) begin
        retrace_i = 1'b0;
        #1 check("R7 paused", copy_valid_o, 0);
        wr(0, 16'h0000);
        rd(0, d); check("R9 write 0 keeps pending", d[2], 1);
      end
    end
    check("R7 all entries streamed", errs, 0);
    rd(0, d); check("R9 self clear", d[2], 0);
    check("R9 stream stops", copy_valid_o, 0);
    retrace_i = 1'b0;
    wr(maddr(1, 0), 16'h0055);
    rd(maddr(1, 0), d); check("R8 writes resume", d, 16'h0055);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fields();
    t_irq();
    t_ext();
    t_maps();
    t_copy();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule